// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds eight one-bit lock flags that two independent ports (left and right) share. Software on either side uses them to claim a shared resource. It writes a zero to ask for a flag, then reads the flag back. A zero means the flag belongs to the reader. A one means the other side holds it. Writing a one gives the flag up, or withdraws a request that has not yet been granted.

The block remembers a request from the side that does not hold a flag. When the holder gives the flag up, the flag passes at once to the waiting side, and that side does not need to ask again. Both sides always see complementary views of a held flag. Each port latches the value it reads into its own output register. A later write from the other port therefore does not change the value a port has already read. All accesses are synchronous to one clock. The asynchronous active-low reset is released in step with that clock inside the block.

Top module: `sem_bank_2p`

## Requirements
- R1: After reset no flag is held and none is requested. Both data outputs show all ones, and a read of any flag from either side returns all ones.
- R2: A flag is selected by address bits [2:0] only. The upper address bits have no effect on which flag is touched.
- R3: A port accesses the bank only in a cycle where its select input `*_sem_n` is 0 and its chip enable `*_ce_n` is 1. A write attempted while `*_ce_n` is 0 changes no flag.
- R4: A write is a cycle with `*_rw` = 0, and only data bit 0 counts. Bit 0 = 0 requests the flag, bit 0 = 1 releases it or cancels a request. The other data bits are ignored.
- R5: When a free flag is requested by one side only, that side afterwards reads 0 at that address and the other side reads 1.
- R6: A held flag can only be freed by its holder. A request from the non-holder does not take the flag. When the holder releases with no request waiting, both sides read 1.
- R7: If the non-holder requested the flag while it was held (in an earlier cycle or in the release cycle), ownership passes to that side in the cycle of the release.
- R8: A read is a cycle with `*_rw` = 1 and `*_oe_n` = 0 (plus R3). It loads the port's output register, one cycle later, with the side's view of the flag as it stood before any write in the same cycle. That view is copied onto every data bit. The register holds its value in every cycle without a read.
- R9: When both sides request the same free flag in the same cycle, the left side gets it and the right side's request is kept as waiting.
- R10: A write of one from the non-holder withdraws its waiting request and leaves the holder unchanged, so a later release by the holder frees the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_sem_n | input | 1 | Left flag-bank select, active low |
| l_ce_n | input | 1 | Left memory enable; must be 1 for a flag access |
| l_rw | input | 1 | Left direction: 1 read, 0 write |
| l_oe_n | input | 1 | Left output enable for reads, active low |
| l_addr | input | ADDR_W (16) | Left address; bits [2:0] pick the flag |
| l_din | input | DATA_W (16) | Left write data; bit 0 used |
| l_dout | output | DATA_W (16) | Left latched read value on all bits |
| r_sem_n | input | 1 | Right flag-bank select, active low |
| r_ce_n | input | 1 | Right memory enable; must be 1 for a flag access |
| r_rw | input | 1 | Right direction: 1 read, 0 write |
| r_oe_n | input | 1 | Right output enable for reads, active low |
| r_addr | input | ADDR_W (16) | Right address; bits [2:0] pick the flag |
| r_din | input | DATA_W (16) | Right write data; bit 0 used |
| r_dout | output | DATA_W (16) | Right latched read value on all bits |

## Verification
The bench targets five corner cases:
- Same-cycle requests for a free flag. A design that favours the right side, or grants both sides, shows a zero on the wrong port or on both ports.
- A request made while the flag is held. A design that drops the waiting request frees the flag on release instead of handing it over. A design that lets the request take the flag shows the requester a zero too early.
- A cancel followed by a release. A design that keeps the cancelled request hands the flag to a side that withdrew.
- Writes with the chip enable active, and accesses with nonzero upper address bits. A design that decodes these wrongly claims flags it should not.
- Reads on one side while the other side writes. A register that is not frozen shows a read value that changes without a new read.

A long pseudo-random sequence of mixed operations on both ports then compares every read against a model of the requirements.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    HOLD_NONE  = 2'b00,
    HOLD_LEFT  = 2'b01,
    HOLD_RIGHT = 2'b10
  } holder_e;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  localparam int SEL_W  = $clog2(NUM_SEM)
) (
  input  logic               sem_n,
  input  logic               ce_n,
  input  logic               rw,
  input  logic               oe_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  din,
  output logic [NUM_SEM-1:0] req_vec,
  output logic [NUM_SEM-1:0] rel_vec,
  output logic               rd_en,
  output logic [SEL_W-1:0]   rd_idx
);
  logic             acc;
  logic             wr;
  logic [SEL_W-1:0] idx;
  logic             unused_bits;

  assign acc   = ~sem_n & ce_n;
  assign wr    = acc & ~rw;
  assign idx   = addr[SEL_W-1:0];
  assign rd_en = acc & rw & ~oe_n;
  assign rd_idx = idx;
  assign unused_bits = ^{addr[ADDR_W-1:SEL_W], din[DATA_W-1:1]};

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_dec
    assign req_vec[g] = wr & (idx == SEL_W'(g)) & ~din[0];
    assign rel_vec[g] = wr & (idx == SEL_W'(g)) &  din[0];
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic l_req,
  input  logic l_rel,
  input  logic r_req,
  input  logic r_rel,
  output logic l_view,
  output logic r_view
);
  holder_e holder_q, holder_d;
  logic    wait_l_q, wait_l_d;
  logic    wait_r_q, wait_r_d;
  logic    wait_l_eff, wait_r_eff;

  assign wait_l_eff = (wait_l_q & ~l_rel) | l_req;
  assign wait_r_eff = (wait_r_q & ~r_rel) | r_req;

  always_comb begin
    holder_d = holder_q;
    wait_l_d = 1'b0;
    wait_r_d = 1'b0;
    case (holder_q)
      HOLD_NONE: begin
        if (l_req) begin
          holder_d = HOLD_LEFT;
          wait_r_d = r_req;
        end else if (r_req) begin
          holder_d = HOLD_RIGHT;
        end
      end
      HOLD_LEFT: begin
        if (l_rel) holder_d = wait_r_eff ? HOLD_RIGHT : HOLD_NONE;
        else       wait_r_d = wait_r_eff;
      end
      HOLD_RIGHT: begin
        if (r_rel) holder_d = wait_l_eff ? HOLD_LEFT : HOLD_NONE;
        else       wait_l_d = wait_l_eff;
      end
      default: holder_d = HOLD_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holder_q <= HOLD_NONE;
      wait_l_q <= 1'b0;
      wait_r_q <= 1'b0;
    end else begin
      holder_q <= holder_d;
      wait_l_q <= wait_l_d;
      wait_r_q <= wait_r_d;
    end
  end

  assign l_view = (holder_q != HOLD_LEFT);
  assign r_view = (holder_q != HOLD_RIGHT);

  p_hold_left_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (holder_q == HOLD_LEFT && !l_rel) |=> holder_q == HOLD_LEFT);
  p_hold_right_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (holder_q == HOLD_RIGHT && !r_rel) |=> holder_q == HOLD_RIGHT);
  p_handover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (holder_q == HOLD_LEFT && l_rel && ((wait_r_q && !r_rel) || r_req))
      |=> holder_q == HOLD_RIGHT);
  p_tie_left_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (holder_q == HOLD_NONE && l_req && r_req)
      |=> (holder_q == HOLD_LEFT && wait_r_q));
  p_cancel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (holder_q == HOLD_LEFT && r_rel && !l_rel)
      |=> (holder_q == HOLD_LEFT && !wait_r_q));
endmodule

// File: rtl/sem_rd_reg.sv
module sem_rd_reg #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 16,
  localparam int SEL_W  = $clog2(NUM_SEM)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [SEL_W-1:0]   rd_idx,
  input  logic [NUM_SEM-1:0] views,
  output logic [DATA_W-1:0]  dout
);
  logic bit_q, bit_d;

  always_comb begin
    bit_d = bit_q;
    if (rd_en) bit_d = views[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_q <= 1'b1;
    else        bit_q <= bit_d;
  end

  assign dout = {DATA_W{bit_q}};

  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(bit_q));
  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> bit_q == $past(views[rd_idx]));
endmodule

// File: rtl/sem_bank_2p.sv
module sem_bank_2p #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  localparam int SEL_W  = $clog2(NUM_SEM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sem_n,
  input  logic              l_ce_n,
  input  logic              l_rw,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_din,
  output logic [DATA_W-1:0] l_dout,
  input  logic              r_sem_n,
  input  logic              r_ce_n,
  input  logic              r_rw,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_din,
  output logic [DATA_W-1:0] r_dout
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [NUM_SEM-1:0] l_req, l_rel, r_req, r_rel;
  logic [NUM_SEM-1:0] l_views, r_views;
  logic               l_rd_en, r_rd_en;
  logic [SEL_W-1:0]   l_rd_idx, r_rd_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sem_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_l (
    .sem_n(l_sem_n), .ce_n(l_ce_n), .rw(l_rw), .oe_n(l_oe_n),
    .addr(l_addr), .din(l_din),
    .req_vec(l_req), .rel_vec(l_rel), .rd_en(l_rd_en), .rd_idx(l_rd_idx));

  sem_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_r (
    .sem_n(r_sem_n), .ce_n(r_ce_n), .rw(r_rw), .oe_n(r_oe_n),
    .addr(r_addr), .din(r_din),
    .req_vec(r_req), .rel_vec(r_rel), .rd_en(r_rd_en), .rd_idx(r_rd_idx));

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
    sem_cell u_cell (
      .clk(clk), .rst_n(rst_int_n),
      .l_req(l_req[g]), .l_rel(l_rel[g]),
      .r_req(r_req[g]), .r_rel(r_rel[g]),
      .l_view(l_views[g]), .r_view(r_views[g]));
  end

  sem_rd_reg #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_l (
    .clk(clk), .rst_n(rst_int_n), .rd_en(l_rd_en), .rd_idx(l_rd_idx),
    .views(l_views), .dout(l_dout));

  sem_rd_reg #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_r (
    .clk(clk), .rst_n(rst_int_n), .rd_en(r_rd_en), .rd_idx(r_rd_idx),
    .views(r_views), .dout(r_dout));
endmodule

// File: tb/sem_bank_2p_tb.sv
module sem_bank_2p_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int OP_IDLE = 0, OP_W0 = 1, OP_W1 = 2, OP_RD = 3, OP_BLK = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic l_sem_n, l_ce_n, l_rw, l_oe_n, r_sem_n, r_ce_n, r_rw, r_oe_n;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_din, r_din, l_dout, r_dout;

  int n_chk = 0;
  int n_bad = 0;
  int own [NS];
  bit pl [NS];
  bit pr [NS];
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  sem_bank_2p dut_i (
    .clk(clk), .rst_n(rst_n),
    .l_sem_n(l_sem_n), .l_ce_n(l_ce_n), .l_rw(l_rw), .l_oe_n(l_oe_n),
    .l_addr(l_addr), .l_din(l_din), .l_dout(l_dout),
    .r_sem_n(r_sem_n), .r_ce_n(r_ce_n), .r_rw(r_rw), .r_oe_n(r_oe_n),
    .r_addr(r_addr), .r_din(r_din), .r_dout(r_dout));

  task automatic check(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] nxt();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr;
  endfunction

  // reference from the requirements: 0 free, 1 left, 2 right
  function automatic void model(int i, bit lq, bit lr, bit rq, bit rr);
    bit wl, wr;
    wl = (pl[i] & ~lr) | lq;
    wr = (pr[i] & ~rr) | rq;
    case (own[i])
      0: begin
        pl[i] = 0; pr[i] = 0;
        if (lq) begin own[i] = 1; pr[i] = rq; end
        else if (rq) own[i] = 2;
      end
      1: begin
        pl[i] = 0;
        if (lr) begin own[i] = wr ? 2 : 0; pr[i] = 0; end
        else pr[i] = wr;
      end
      default: begin
        pr[i] = 0;
        if (rr) begin own[i] = wl ? 1 : 0; pl[i] = 0; end
        else pl[i] = wl;
      end
    endcase
  endfunction

  task automatic drive_side(bit left, int op, int idx, logic [15:0] rnd);
    logic sn, cn, rw, oe;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    sn = (op == OP_IDLE); cn = (op != OP_BLK);
    rw = (op == OP_RD || op == OP_IDLE); oe = (op != OP_RD);
    a = {rnd[15:3], 3'(idx)};
    d = {rnd[14:0], (op == OP_W1)};
    if (left) begin
      l_sem_n = sn; l_ce_n = cn; l_rw = rw; l_oe_n = oe; l_addr = a; l_din = d;
    end else begin
      r_sem_n = sn; r_ce_n = cn; r_rw = rw; r_oe_n = oe; r_addr = a; r_din = d;
    end
  endtask

  task automatic step(int lop, int li, int rop, int ri, string tag);
    logic el, er;
    @(negedge clk);
    drive_side(1'b1, lop, li, nxt());
    drive_side(1'b0, rop, ri, nxt());
    el = (own[li] != 1);
    er = (own[ri] != 2);
    for (int i = 0; i < NS; i++)
      model(i, lop == OP_W0 && li == i, lop == OP_W1 && li == i,
               rop == OP_W0 && ri == i, rop == OP_W1 && ri == i);
    @(posedge clk); #1;
    if (lop == OP_RD) check({tag, " left"}, l_dout, {DW{el}});
    if (rop == OP_RD) check({tag, " right"}, r_dout, {DW{er}});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++) begin own[i] = 0; pl[i] = 0; pr[i] = 0; end
    rst_n = 1'b0;
    drive_side(1'b1, OP_IDLE, 0, 16'h0);
    drive_side(1'b0, OP_IDLE, 0, 16'h0);
    repeat (3) @(posedge clk);
    #1 check("R1 reset dout left", l_dout, '1);
    check("R1 reset dout right", r_dout, '1);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    for (int i = 0; i < NS; i++) step(OP_RD, i, OP_RD, i, "R1 reset read");

    // R5 claim, R6 blocked request, R7 handover, R6 release
    step(OP_W0, 3, OP_IDLE, 0, "R5");
    step(OP_RD, 3, OP_RD, 3, "R5 claim view");
    step(OP_IDLE, 0, OP_W0, 3, "R6");
    step(OP_RD, 3, OP_RD, 3, "R6 nonholder request");
    step(OP_W1, 3, OP_IDLE, 0, "R7");
    step(OP_RD, 3, OP_RD, 3, "R7 handover");
    step(OP_IDLE, 0, OP_W1, 3, "R6");
    step(OP_RD, 3, OP_RD, 3, "R6 release free");

    // R9 tie, R10 cancel
    step(OP_W0, 5, OP_W0, 5, "R9");
    step(OP_RD, 5, OP_RD, 5, "R9 tie left wins");
    step(OP_IDLE, 0, OP_W1, 5, "R10");
    step(OP_RD, 5, OP_RD, 5, "R10 cancel holder kept");
    step(OP_W1, 5, OP_IDLE, 0, "R10");
    step(OP_RD, 5, OP_RD, 5, "R10 free after cancel");

    // R3 chip enable blocks, R2/R4 via random upper bits and data
    step(OP_BLK, 0, OP_BLK, 1, "R3");
    step(OP_RD, 0, OP_RD, 1, "R3 blocked write");
    step(OP_W0, 2, OP_W0, 6, "R2 R4");
    step(OP_RD, 2, OP_RD, 2, "R2 R4 claim by low bits");
    step(OP_RD, 6, OP_RD, 6, "R4 bit0 request");

    // R8 frozen register
    step(OP_RD, 1, OP_IDLE, 0, "R8 read free");
    step(OP_IDLE, 0, OP_W0, 1, "R8");
    step(OP_IDLE, 0, OP_IDLE, 0, "R8");
    check("R8 left frozen", l_dout, '1);
    step(OP_RD, 1, OP_RD, 1, "R8 new read");

    // mixed sweep
    for (int k = 0; k < 4000; k++) begin
      logic [15:0] v;
      v = nxt();
      step(int'(v[2:0]) % 5, int'(v[5:3]), int'(v[8:6]) % 5, int'(v[11:9]),
           "R2 R3 R4 R5 R6 R7 R9 R10 sweep");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule